// File: doc/BRIEF.md
# Masked I/O Address Classifier

This block sits next to a level-one data cache and flags every request address that falls inside one of four programmable I/O windows. Each window is described by a base value and a mask. An address belongs to a window when the address bits outside the mask equal the base. A window whose mask is zero is switched off. The block only produces a flag. The address itself is not translated and is used downstream exactly as presented.

The window registers are loaded by snooping a broadcast configuration-update bus. A write to a window's base or mask lands in a shadow copy and leaves classification unchanged. A write to a dedicated commit location copies all eight shadow values into the active set on one clock edge. Software can therefore rebuild the whole map without the cache ever seeing a half-updated window.

Top module: `io_window_classifier`

## Requirements
- R1: After reset, window 0 holds the parameter values `INIT_BASE` and `INIT_MASK` in both the shadow and active copies, and windows 1 to 3 hold zero base and zero mask.
- R2: `isIo` is 1 when at least one enabled window satisfies `(reqAddr & ~mask) == base` on its active values, and 0 otherwise. This holds for masks that are not contiguous.
- R3: A window whose active mask is zero never matches, even when `reqAddr` equals its base.
- R4: A bus write to a base location (`0x7b0 + 4*i`) or a mask location (`0x7b1 + 4*i`), for window i = 0..3, changes only that window's shadow value and leaves `isIo` unchanged.
- R5: A bus write to `0x7bf` copies every shadow base and mask into the active set at one clock edge. The new map applies to addresses presented after that edge, and the shadow values are kept.
- R6: `isIo` is a combinational function of `reqAddr` and the active map. A change of `reqAddr` shows on `isIo` with no clock edge in between.
- R7: A bus write to any other location, such as `0x7b2`, `0x7b3`, `0x7bb` or `0x7a0`, changes neither the shadow nor the active values. A cycle with `updValid` low also has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| updValid | input | 1 | A configuration-bus write is present this cycle |
| updAddr | input | CSR_W (12) | Register location of the bus write |
| updData | input | ADDR_W | Value carried by the bus write |
| reqAddr | input | ADDR_W | Request address to classify |
| isIo | output | 1 | Request address lies in an enabled I/O window |

## Verification
The flag depends only on `reqAddr` and the active map, so it is due in the same cycle that an address is presented. The bench drives each address after a falling edge and samples one time unit later, with no rising edge in between. A bus write takes effect at the first rising edge after it is driven. The bench updates its own shadow and active model at that edge and does all following samples after it. This proves that shadow writes leave the flag alone and that a commit is seen on the very next presented address. Directed cases cover reset values, zero masks and discontiguous masks. A seeded random mix of writes, commits and addresses near each window then goes through the same reference function.

// File: rtl/io_window_pkg.sv
package io_window_pkg;

  // number of I/O windows and width of the update-bus location field
  localparam int unsigned SEC_NUM = 4;
  localparam int unsigned CSR_W   = 12;

  // bus locations: window i base at SEC_FIRST + SEC_STRIDE*i, mask one above
  localparam logic [CSR_W-1:0] SEC_FIRST   = 12'h7b0;
  localparam int unsigned      SEC_STRIDE  = 4;
  localparam logic [CSR_W-1:0] COMMIT_LOC  = 12'h7bf;

  // strobes handed from the decoder to the register datapath
  typedef struct packed {
    logic [SEC_NUM-1:0] baseWe;
    logic [SEC_NUM-1:0] maskWe;
    logic               commit;
  } winStrobe_t;

endpackage

// File: rtl/io_window_ctrl.sv
module io_window_ctrl
  import io_window_pkg::*;
(
  input  logic             updValid,
  input  logic [CSR_W-1:0] updAddr,
  output winStrobe_t       strobe
);

  always_comb begin
    strobe = '0;
    if (updValid) begin
      strobe.commit = (updAddr == COMMIT_LOC);
      for (int i = 0; i < SEC_NUM; i++) begin
        strobe.baseWe[i] = (updAddr == CSR_W'(SEC_FIRST + SEC_STRIDE * i));
        strobe.maskWe[i] = (updAddr == CSR_W'(SEC_FIRST + SEC_STRIDE * i + 1));
      end
    end
  end

endmodule

// File: rtl/io_window_dp.sv
module io_window_dp
  import io_window_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 32,
  parameter logic [ADDR_W-1:0]  INIT_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0]  INIT_MASK = 32'h0000_ffff
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobe_t        strobe,
  input  logic [ADDR_W-1:0] updData,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [SEC_NUM-1:0] secHit
);

  for (genvar g = 0; g < SEC_NUM; g++) begin : gSec
    localparam logic [ADDR_W-1:0] RST_BASE = (g == 0) ? INIT_BASE : '0;
    localparam logic [ADDR_W-1:0] RST_MASK = (g == 0) ? INIT_MASK : '0;

    logic [ADDR_W-1:0] shadowBase, shadowMask;
    logic [ADDR_W-1:0] activeBase, activeMask;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadowBase <= RST_BASE;
        shadowMask <= RST_MASK;
      end else begin
        if (strobe.baseWe[g]) shadowBase <= updData;
        if (strobe.maskWe[g]) shadowMask <= updData;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        activeBase <= RST_BASE;
        activeMask <= RST_MASK;
      end else if (strobe.commit) begin
        activeBase <= shadowBase;
        activeMask <= shadowMask;
      end
    end

    assign secHit[g] = (|activeMask) && ((reqAddr & ~activeMask) == activeBase);
  end

endmodule

// File: rtl/io_window_classifier.sv
module io_window_classifier
  import io_window_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 32,
  parameter logic [ADDR_W-1:0]  INIT_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0]  INIT_MASK = 32'h0000_ffff
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              updValid,
  input  logic [CSR_W-1:0]  updAddr,
  input  logic [ADDR_W-1:0] updData,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              isIo
);

  winStrobe_t         strobe;
  logic [SEC_NUM-1:0] secHit;

  io_window_ctrl u_ctrl (
    .updValid (updValid),
    .updAddr  (updAddr),
    .strobe   (strobe)
  );

  io_window_dp #(
    .ADDR_W    (ADDR_W),
    .INIT_BASE (INIT_BASE),
    .INIT_MASK (INIT_MASK)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .updData (updData),
    .reqAddr (reqAddr),
    .secHit  (secHit)
  );

  assign isIo = |secHit;

endmodule

// File: rtl/io_window_chk.sv
module io_window_chk
  import io_window_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 32,
  parameter logic [ADDR_W-1:0]  INIT_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0]  INIT_MASK = 32'h0000_ffff
) (
  input logic              clk,
  input logic              rstN,
  input logic              updValid,
  input logic [CSR_W-1:0]  updAddr,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              isIo,
  input winStrobe_t        strobe
);

  logic commitSeen;
  assign commitSeen = updValid && (updAddr == COMMIT_LOC);

  // R1
  reset_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (isIo == ((INIT_MASK != '0) && ((reqAddr & ~INIT_MASK) == INIT_BASE))));

  // R4
  shadow_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(reqAddr) && !$past(commitSeen)) |-> $stable(isIo));

  // R7
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.baseWe, strobe.maskWe, strobe.commit}) <= 1);

  // R7
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |-> (strobe == '0));

  // R6
  known_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(isIo));

endmodule

bind io_window_classifier io_window_chk #(
  .ADDR_W    (ADDR_W),
  .INIT_BASE (INIT_BASE),
  .INIT_MASK (INIT_MASK)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .updValid (updValid),
  .updAddr  (updAddr),
  .reqAddr  (reqAddr),
  .isIo     (isIo),
  .strobe   (strobe)
);

// File: tb/sim_io_window_classifier.sv
module sim_io_window_classifier;

  localparam int unsigned       PERIOD    = 10;
  localparam int unsigned       ADDR_W    = 32;
  localparam logic [ADDR_W-1:0] INIT_BASE = 32'h4000_0000;
  localparam logic [ADDR_W-1:0] INIT_MASK = 32'h0000_ffff;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              updValid = 1'b0;
  logic [11:0]       updAddr = '0;
  logic [ADDR_W-1:0] updData = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              isIo;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [ADDR_W-1:0] shBase [4];
  logic [ADDR_W-1:0] shMask [4];
  logic [ADDR_W-1:0] acBase [4];
  logic [ADDR_W-1:0] acMask [4];

  always #(PERIOD/2) clk = ~clk;

  io_window_classifier #(
    .ADDR_W    (ADDR_W),
    .INIT_BASE (INIT_BASE),
    .INIT_MASK (INIT_MASK)
  ) u0 (
    .clk      (clk),
    .rstN     (rstN),
    .updValid (updValid),
    .updAddr  (updAddr),
    .updData  (updData),
    .reqAddr  (reqAddr),
    .isIo     (isIo)
  );

  function automatic logic expIo(logic [ADDR_W-1:0] a);
    logic r = 1'b0;
    for (int i = 0; i < 4; i++)
      if (acMask[i] != '0 && ((a & ~acMask[i]) == acBase[i])) r = 1'b1;
    return r;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 4; i++) begin
      shBase[i] = (i == 0) ? INIT_BASE : '0;
      shMask[i] = (i == 0) ? INIT_MASK : '0;
      acBase[i] = shBase[i];
      acMask[i] = shMask[i];
    end
  endtask

  // bus write: driven after a falling edge, takes effect at the next rising edge
  task automatic busWrite(logic [11:0] loc, logic [ADDR_W-1:0] val);
    @(negedge clk);
    updValid = 1'b1;
    updAddr  = loc;
    updData  = val;
    @(posedge clk);
    #1;
    for (int i = 0; i < 4; i++) begin
      if (loc == 12'(12'h7b0 + 4*i))     shBase[i] = val;
      if (loc == 12'(12'h7b0 + 4*i + 1)) shMask[i] = val;
    end
    if (loc == 12'h7bf)
      for (int i = 0; i < 4; i++) begin
        acBase[i] = shBase[i];
        acMask[i] = shMask[i];
      end
    updValid = 1'b0;
  endtask

  task automatic checkNow(logic [ADDR_W-1:0] a, string req);
    reqAddr = a;
    #1;
    checks++;
    if (isIo !== expIo(a)) begin
      errors++;
      $display("FAIL %s addr=%h isIo=%b expected=%b", req, a, isIo, expIo(a));
    end
  endtask

  task automatic checkAddr(logic [ADDR_W-1:0] a, string req);
    @(negedge clk);
    checkNow(a, req);
  endtask

  task automatic checkLit(logic [ADDR_W-1:0] a, logic exp, string req);
    @(negedge clk);
    reqAddr = a;
    #1;
    checks++;
    if (isIo !== exp) begin
      errors++;
      $display("FAIL %s addr=%h isIo=%b expected=%b", req, a, isIo, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] nearAddr(int k);
    logic [ADDR_W-1:0] a = (shBase[k] & ~shMask[k]) | ($urandom & shMask[k]);
    if ($urandom_range(3) == 0) a = a ^ (ADDR_W'(1) << $urandom_range(ADDR_W-1));
    return a;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset map
    checkLit(INIT_BASE | 32'h1234, 1'b1, "R1");
    checkLit(INIT_BASE + 32'h0001_0000, 1'b0, "R1");
    // R3: address 0 equals the zero base of disabled windows
    checkLit(32'h0, 1'b0, "R3");

    // R4: shadow write leaves flag alone
    busWrite(12'h7b4, 32'h1000_0000);
    busWrite(12'h7b5, 32'h0000_0fff);
    checkLit(32'h1000_0010, 1'b0, "R4");
    // R5: commit applies the shadow on the next presented address
    busWrite(12'h7bf, 32'h0);
    checkLit(32'h1000_0010, 1'b1, "R5");
    checkLit(32'h1000_1000, 1'b0, "R2");
    checkLit(INIT_BASE | 32'h00ff, 1'b1, "R5");

    // R3: zero mask disables window even on exact base
    busWrite(12'h7b8, 32'h2000_0000);
    busWrite(12'h7b9, 32'h0);
    busWrite(12'h7bf, 32'h0);
    checkLit(32'h2000_0000, 1'b0, "R3");

    // R2: discontiguous mask
    busWrite(12'h7bc, 32'h3000_0000);
    busWrite(12'h7bd, 32'h0000_00f0);
    busWrite(12'h7bf, 32'h0);
    checkLit(32'h3000_0050, 1'b1, "R2");
    checkLit(32'h3000_0051, 1'b0, "R2");

    // R7: unmapped locations leave shadow and active untouched
    busWrite(12'h7b2, 32'hffff_ffff);
    busWrite(12'h7b3, 32'hffff_ffff);
    busWrite(12'h7bb, 32'hffff_ffff);
    busWrite(12'h7a0, 32'hffff_ffff);
    checkLit(32'h1000_0abc, 1'b1, "R7");
    busWrite(12'h7bf, 32'h0);
    checkLit(32'h1000_0abc, 1'b1, "R7");
    checkLit(32'h5555_0000, 1'b0, "R7");
    // R7: valid low ignored
    @(negedge clk);
    updAddr = 12'h7bf; updData = 32'h0; updValid = 1'b0;
    @(negedge clk);
    updAddr = 12'h7b4; updData = 32'h5555_0000;
    @(negedge clk);
    updAddr = 12'h000;
    busWrite(12'h7bf, 32'h0);
    checkLit(32'h1000_0abc, 1'b1, "R7");
    checkLit(32'h5555_0000, 1'b0, "R7");

    // R5: all four windows replaced at one edge
    for (int i = 0; i < 4; i++) begin
      busWrite(12'(12'h7b0 + 4*i), ADDR_W'(32'h6000_0000 + i * 32'h0100_0000));
      busWrite(12'(12'h7b0 + 4*i + 1), 32'h0000_ffff);
    end
    checkLit(32'h6000_0010, 1'b0, "R4");
    checkLit(32'h1000_0010, 1'b1, "R4");
    busWrite(12'h7bf, 32'h0);
    for (int i = 0; i < 4; i++)
      checkLit(ADDR_W'(32'h6000_1234 + i * 32'h0100_0000), 1'b1, "R5");
    checkLit(32'h1000_0010, 1'b0, "R5");

    // R6: address change seen with no clock edge in between
    @(negedge clk);
    checkNow(32'h6100_0001, "R6");
    checkNow(32'h7000_0001, "R6");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(9);
      int k  = $urandom_range(3);
      if (op < 2) begin
        logic [ADDR_W-1:0] m = ($urandom_range(4) == 0) ? '0 : (($urandom | 32'h1) >> $urandom_range(31));
        busWrite(12'(12'h7b1 + 4*k), m);
      end else if (op < 4) begin
        busWrite(12'(12'h7b0 + 4*k), $urandom & ~shMask[k]);
      end else if (op == 4) begin
        busWrite(12'h7bf, 32'h0);
      end else if (op == 5) begin
        busWrite(12'(12'h7b2 + 4*k), $urandom);
      end else begin
        checkAddr(nearAddr(k), "R2");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule